// File: doc/BRIEF.md
# Reset-Gated Timing Pulse Generator

This block turns a periodic reference tick into a timing pulse at one of two rates. With the rate control low, the pulse line flips on every reference tick. With the rate control high, a divider counts `SLOW_DIV` ticks and raises the line for exactly one tick interval each time it wraps. At the default of 10240 ticks on a 1024 Hz reference, that is one pulse every 10 seconds.

Initialization is handled by a small state machine. A power-on strobe, or a write of 1 to the reset control bit, parks the block in a held state. While held, the pulse line is forced low, the divider is cleared, and `init_busy_o` is raised. The surrounding time/calendar logic uses `init_busy_o` as its request to load its initial values. Release takes two steps: chip select must rise, and a later falling serial clock completes it. After release, the divider starts from zero, so the first slow pulse comes one full period later. A sticky power-on flag is set by the strobe and is cleared only by an explicit reset-bit write.

States and transitions:

- `ST_HELD`: goes to `ST_ARMED` on a chip-select rise, unless a reset write arrives in the same cycle.
- `ST_ARMED`: goes to `ST_FAST` or `ST_SLOW` on a serial-clock fall, chosen by the rate bit. A reset write sends it back to `ST_HELD`.
- `ST_FAST` and `ST_SLOW`: each switches to the other when the rate bit disagrees with it. A reset write sends either one to `ST_HELD`.
- The power-on strobe sends any state to `ST_HELD` asynchronously.

Top module: `tick_pulse_gen`

## Requirements
- R1: While `por_i` is high, the outputs take `pulse_o`=0, `init_busy_o`=1 and `pon_flag_o`=1 at once, without waiting for a clock edge.
- R2: `pon_flag_o` keeps the value 1 through the release handshake and through any number of ticks. It falls to 0 only at the clock edge that takes a `sysrst_wr_i` strobe.
- R3: A `sysrst_wr_i` strobe in any state gives `init_busy_o`=1 and `pulse_o`=0 after the next clock edge.
- R4: While `init_busy_o` is 1, `pulse_o` stays 0 and reference ticks have no effect on it.
- R5: Release needs a 0-to-1 change on `cs_i` followed by a 1-to-0 change on `sck_i` in a later cycle. A serial-clock fall with no chip-select rise before it leaves the block held. When both changes occur in the same cycle, only the rise counts.
- R6: With `rate_sel_i`=0 the block is in fast mode, and `pulse_o` inverts at the clock edge that takes each reference tick.
- R7: With `rate_sel_i`=1 the block is in slow mode. `pulse_o` goes to 1 at the edge that takes every `SLOW_DIV`-th tick counted from release or from the last rate change, and returns to 0 at the next tick.
- R8: A change of `rate_sel_i` while running drives `pulse_o` to 0 at the next edge and restarts the divider from zero.
- R9: In the armed state, a `sysrst_wr_i` strobe takes priority over a serial-clock fall in the same cycle. A new chip-select rise is then needed before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are synchronous to it |
| por_i | input | 1 | Power-on strobe, active high, asynchronous |
| ref_tick_i | input | 1 | One-cycle strobe per reference period |
| rate_sel_i | input | 1 | 0 = fast (toggle per tick), 1 = slow (one pulse per `SLOW_DIV` ticks) |
| sysrst_wr_i | input | 1 | One-cycle strobe: reset control bit written with 1 |
| cs_i | input | 1 | Chip select level; its rise arms release |
| sck_i | input | 1 | Serial clock level; its fall completes release |
| pulse_o | output | 1 | Timing pulse output |
| init_busy_o | output | 1 | Reset in progress; also the clear request to the calendar |
| pon_flag_o | output | 1 | Sticky power-on flag |

## Verification
Fast mode is driven with ticks that come back to back and with ticks separated by idle cycles. This shows that the line inverts on each tick and never on the clock alone. Slow mode is run for more than one divider period with gapped ticks, which separates a pulse at the wrap count from one that is a tick early or late. Rate changes are made in both directions, with a tick in the same cycle, to show that the change wins over the tick. The release handshake is tried with the edges in the right order, with a serial-clock fall that has no chip-select rise before it, with both edges in one cycle, and against a reset write in the same cycle. Each of these sequences has a different correct number of held cycles.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic [1:0] {
        ST_HELD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FAST  = 2'd2,
        ST_SLOW  = 2'd3
    } tpg_state_e;
endpackage

// File: rtl/tpg_edge.sv
module tpg_edge #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] lvl_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or posedge por_i) begin
            if (por_i) lvl_q[g] <= RST_VAL[g];
            else       lvl_q[g] <= lvl_i[g];
        end
        assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
        assign fall_o[g] = ~lvl_i[g] & lvl_q[g];
    end
endmodule

// File: rtl/tpg_divider.sv
module tpg_divider #(
    parameter int DIV = 10240
) (
    input  logic clk,
    input  logic por_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic wrap_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign wrap_o = tick_i && (cnt_q == LAST);

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)        cnt_q <= '0;
        else if (clr_i)   cnt_q <= '0;
        else if (wrap_o)  cnt_q <= '0;
        else if (tick_i)  cnt_q <= cnt_q + 1'b1;
    end

    // R7: the count never leaves its range
    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (por_i)
        cnt_q <= LAST);
endmodule

// File: rtl/tpg_fsm.sv
module tpg_fsm
    import tpg_pkg::*;
(
    input  logic clk,
    input  logic por_i,
    input  logic tick_i,
    input  logic rate_i,
    input  logic wr_i,
    input  logic cs_rise_i,
    input  logic sck_fall_i,
    input  logic wrap_i,
    output logic div_clr_o,
    output logic pulse_o,
    output logic busy_o,
    output logic pon_o
);
    tpg_state_e state_q, state_d;
    logic       running, mismatch;

    assign running   = (state_q == ST_FAST) || (state_q == ST_SLOW);
    assign mismatch  = ((state_q == ST_FAST) && rate_i) ||
                       ((state_q == ST_SLOW) && !rate_i);
    assign div_clr_o = !running || mismatch || wr_i;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) state_q <= ST_HELD;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HELD:  if (!wr_i && cs_rise_i) state_d = ST_ARMED;
            ST_ARMED: if (wr_i)               state_d = ST_HELD;
                      else if (sck_fall_i)    state_d = rate_i ? ST_SLOW : ST_FAST;
            ST_FAST:  if (wr_i)               state_d = ST_HELD;
                      else if (rate_i)        state_d = ST_SLOW;
            ST_SLOW:  if (wr_i)               state_d = ST_HELD;
                      else if (!rate_i)       state_d = ST_FAST;
            default:                          state_d = ST_HELD;
        endcase
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            pulse_o <= 1'b0;
            busy_o  <= 1'b1;
            pon_o   <= 1'b1;
        end else begin
            busy_o <= (state_d == ST_HELD) || (state_d == ST_ARMED);
            if (wr_i) pon_o <= 1'b0;
            if (wr_i || mismatch) begin
                pulse_o <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_HELD, ST_ARMED: pulse_o <= 1'b0;
                    ST_FAST:           if (tick_i) pulse_o <= ~pulse_o;
                    ST_SLOW:           if (tick_i) pulse_o <= wrap_i;
                    default:           pulse_o <= 1'b0;
                endcase
            end
        end
    end

    assert_pon_clear_by_write_R2: assert property (@(posedge clk) disable iff (por_i)
        $fell(pon_o) |-> $past(wr_i));
    assert_write_holds_R3: assert property (@(posedge clk) disable iff (por_i)
        wr_i |=> (busy_o && !pulse_o));
    assert_quiet_when_busy_R4: assert property (@(posedge clk) disable iff (por_i)
        busy_o |-> !pulse_o);
    assert_release_on_sck_R5: assert property (@(posedge clk) disable iff (por_i)
        $fell(busy_o) |-> ($past(sck_fall_i) && !$past(wr_i)));
    assert_edge_needs_tick_R6: assert property (@(posedge clk) disable iff (por_i)
        $rose(pulse_o) |-> $past(tick_i));
    assert_rate_change_low_R8: assert property (@(posedge clk) disable iff (por_i)
        mismatch |=> !pulse_o);
endmodule

// File: rtl/tick_pulse_gen.sv
module tick_pulse_gen #(
    parameter int SLOW_DIV = 10240
) (
    input  logic clk,
    input  logic por_i,
    input  logic ref_tick_i,
    input  logic rate_sel_i,
    input  logic sysrst_wr_i,
    input  logic cs_i,
    input  logic sck_i,
    output logic pulse_o,
    output logic init_busy_o,
    output logic pon_flag_o
);
    logic [1:0] lvl_rise, lvl_fall;
    logic       div_clr, div_wrap;

    // bit 1 = chip select (idle high after power-on), bit 0 = serial clock
    tpg_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
        .clk    (clk),
        .por_i  (por_i),
        .lvl_i  ({cs_i, sck_i}),
        .rise_o (lvl_rise),
        .fall_o (lvl_fall)
    );

    tpg_divider #(.DIV(SLOW_DIV)) u_div (
        .clk    (clk),
        .por_i  (por_i),
        .clr_i  (div_clr),
        .tick_i (ref_tick_i),
        .wrap_o (div_wrap)
    );

    tpg_fsm u_fsm (
        .clk        (clk),
        .por_i      (por_i),
        .tick_i     (ref_tick_i),
        .rate_i     (rate_sel_i),
        .wr_i       (sysrst_wr_i),
        .cs_rise_i  (lvl_rise[1]),
        .sck_fall_i (lvl_fall[0]),
        .wrap_i     (div_wrap),
        .div_clr_o  (div_clr),
        .pulse_o    (pulse_o),
        .busy_o     (init_busy_o),
        .pon_o      (pon_flag_o)
    );
endmodule

// File: tb/tick_pulse_gen_test.sv
module tick_pulse_gen_test;
    localparam int DIV = 3;
    localparam int NV  = 32;
    // {por, wr, cs, sck, rate, tick, exp_pulse, exp_busy, exp_pon}
    localparam logic [8:0] VEC [NV] = '{
        9'b100100_011, 9'b000100_011, 9'b000101_011, 9'b000000_011,
        9'b000100_011, 9'b001100_011, 9'b001101_011, 9'b001000_001,
        9'b001101_101, 9'b001100_101, 9'b001101_001, 9'b001101_101,
        9'b001111_001, 9'b001111_001, 9'b001111_001, 9'b001110_001,
        9'b001111_101, 9'b001110_101, 9'b001111_001, 9'b001111_001,
        9'b001101_001, 9'b001101_101, 9'b011100_010, 9'b001101_010,
        9'b000100_010, 9'b001100_010, 9'b001110_010, 9'b001010_000,
        9'b001111_000, 9'b001111_000, 9'b001111_100, 9'b001111_000
    };

    logic clk = 1'b0;
    logic por, tick, rate, wr, cs, sck;
    logic pulse, busy, pon;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    tick_pulse_gen #(.SLOW_DIV(DIV)) uut (
        .clk(clk), .por_i(por), .ref_tick_i(tick), .rate_sel_i(rate),
        .sysrst_wr_i(wr), .cs_i(cs), .sck_i(sck),
        .pulse_o(pulse), .init_busy_o(busy), .pon_flag_o(pon)
    );

    function automatic string req_of(int i);
        if (i < 2)   return "R1";
        if (i < 5)   return "R4/R5";
        if (i < 8)   return "R5";
        if (i < 12)  return "R6";
        if (i == 12) return "R8";
        if (i < 20)  return "R7";
        if (i < 22)  return "R8";
        if (i < 24)  return "R2/R3";
        if (i < 28)  return "R5";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if ({pulse, busy, pon} !== exp) begin
            n_bad++;
            $display("FAIL %s: got pulse/busy/pon=%b expected %b", req, {pulse, busy, pon}, exp);
        end
    endtask

    task automatic drive(input logic [5:0] s);
        {por, wr, cs, sck, rate, tick} = s;
    endtask

    initial begin
        drive(6'b100100);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][8:3]);
            @(negedge clk);
            check(req_of(i), VEC[i][2:0]);
        end

        // R1: asynchronous power-on strobe from the running slow state
        #2 por = 1'b1;
        #2 check("R1", 3'b011);
        @(negedge clk);
        drive(6'b000100);
        @(negedge clk); check("R2", 3'b011);
        // R5: chip-select rise and serial-clock fall in the same cycle
        drive(6'b000100); @(negedge clk);
        drive(6'b001000); @(negedge clk); check("R5", 3'b011);
        drive(6'b001101); @(negedge clk); check("R4", 3'b011);
        drive(6'b001000); @(negedge clk); check("R5", 3'b001);
        // R9: reset write wins over serial-clock fall in armed state
        drive(6'b011100); @(negedge clk); check("R3", 3'b010);
        drive(6'b000100); @(negedge clk);
        drive(6'b001100); @(negedge clk); check("R9", 3'b010);
        drive(6'b011000); @(negedge clk); check("R9", 3'b010);
        drive(6'b001100); @(negedge clk);
        drive(6'b001000); @(negedge clk); check("R9", 3'b010);
        drive(6'b001100); @(negedge clk);
        drive(6'b000100); @(negedge clk);
        drive(6'b001100); @(negedge clk);
        drive(6'b001000); @(negedge clk); check("R5", 3'b000);
        // R6: fast toggling with gapped ticks
        drive(6'b001001); @(negedge clk); check("R6", 3'b100);
        drive(6'b001000); @(negedge clk); check("R6", 3'b100);
        drive(6'b001001); @(negedge clk); check("R6", 3'b000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule